// File: doc/BRIEF.md
# Privileged Trap Entry and Register Shadowing Unit

This unit decides where a small 64-bit core goes when it enters or leaves its privileged handler mode. Each cycle it sees the current PC, the handler base address, a trap request with a fault code, and a return request. When a trap is taken, it produces the handler entry PC and the PC after it, and updates the saved exception address. A legal return sends the core back to that saved address.

Handler mode is marked by bit 0 of the PC. Entering a handler from ordinary code switches a shadow-select. While the shadow-select is on, integer registers 8 to 14 and register 25 are served from a private eight-entry shadow array. A return whose target has bit 0 clear switches the shadow-select off again and asks the core to re-check pending interrupts.

The integer register file itself lives outside this unit. The unit only reports whether an access is redirected, and holds the shadow array. All outputs are registered, so a request accepted at one clock edge shows up on the outputs after that same edge.

Top module: `trap_entry_unit`

## Requirements
- R1: During synchronous reset the unit sets `shadow_o` to 1, `pc_o` to `base_i`+0x1, `npc_o` to `base_i`+0x5 and `exc_addr_o` to 0, and clears `jump_o`, `recheck_o` and `state_err_o`.
- R2: When a trap is accepted, `pc_o` becomes `base_i` plus the entry offset of `fault_i`. The codes map as follows: 0→0x401, 1→0x501, 2→0x101, 3→0x201, 4→0x281, 5→0x301, 6→0x381, 7→0x381, 8→0x181, 9→0x181, 10→0x081, 11→0x481, 12→0x581, 13→0x2001, 14→0x501.
- R3: Every accepted trap or return raises `jump_o` for exactly one cycle after the accepting edge, with `npc_o` equal to `pc_o`+4.
- R4: A trap stores `pc_i` into `exc_addr_o`. The one exception is code 2 (interrupt) taken while `pc_i[0]`=1, which leaves `exc_addr_o` unchanged.
- R5: For code 1 (arithmetic) and code 13 (privileged call), the stored exception address is `pc_i`+4.
- R6: A trap taken with `pc_i[0]`=0 sets `shadow_o`. A trap taken with `pc_i[0]`=1 leaves `shadow_o` unchanged.
- R7: A return request with `pc_i[0]`=1 loads `pc_o` from `exc_addr_o` and pulses `recheck_o` for one cycle. It clears `shadow_o` only when bit 0 of `exc_addr_o` is 0.
- R8: A return request with `pc_i[0]`=0 is illegal. It is handled as a trap with code 11: offset 0x481, exception address = `pc_i`, shadow entry as in R6, and no `recheck_o`.
- R9: `state_err_o` pulses for one cycle when a shadow change is asked for while the shadow-select is already in that state. This covers a trap with `pc_i[0]`=0 while `shadow_o`=1, and a legal return to an even address while `shadow_o`=0.
- R10: When a trap request and a return request arrive in the same cycle, only the trap is performed.
- R11: While `shadow_o`=1, accesses to registers 8–14 and 25 use the shadow array. `rf_hit_o` and `rf_rdata_o` report the access one cycle later. Writes to those registers while `shadow_o`=0, and writes to any other register, leave the shadow array unchanged.
- R12: Code 15 is reserved and uses offset 0x481, with the same exception address rule as other codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_i | input | 64 | Handler base address |
| pc_i | input | 64 | PC of the instruction raising the request |
| trap_req_i | input | 1 | Trap request, one cycle |
| fault_i | input | 4 | Fault code of the trap |
| ret_req_i | input | 1 | Handler return request, one cycle |
| rf_we_i | input | 1 | Register write strobe |
| rf_addr_i | input | 5 | Register number |
| rf_wdata_i | input | 64 | Register write data |
| pc_o | output | 64 | New PC |
| npc_o | output | 64 | PC following the new PC |
| exc_addr_o | output | 64 | Saved exception address |
| shadow_o | output | 1 | Shadow bank selected |
| jump_o | output | 1 | pc_o/npc_o were loaded at the last edge |
| recheck_o | output | 1 | Re-check pending interrupts |
| state_err_o | output | 1 | Redundant shadow change requested |
| rf_rdata_o | output | 64 | Shadow array read data |
| rf_hit_o | output | 1 | Last access was redirected to the shadow array |

## Verification
The hardest states to reach are the redundant shadow changes and a return that stays in shadow mode. A normal sequence of traps and returns never produces either one. The stimulus gets there by driving `pc_i` values that do not match the current shadow-select: an even PC while the shadow is still on, or a second legal return after the shadow has already been cleared. To make a return keep the shadow on, the bench first takes a trap from an odd handler-mode PC, which leaves an odd saved address. The retention test for the shadow array writes a register outside shadow mode, then re-enters shadow mode and reads the old value back.

// File: rtl/tev_pkg.sv
package tev_pkg;

  typedef enum logic [3:0] {
    F_MCHK    = 4'd0,
    F_ARITH   = 4'd1,
    F_INTR    = 4'd2,
    F_NDTB    = 4'd3,
    F_PDTB    = 4'd4,
    F_ALIGN   = 4'd5,
    F_DTBF    = 4'd6,
    F_DTBACV  = 4'd7,
    F_ITBMISS = 4'd8,
    F_ITBF    = 4'd9,
    F_ITBACV  = 4'd10,
    F_OPCODE  = 4'd11,
    F_FEN     = 4'd12,
    F_PALCALL = 4'd13,
    F_OVF     = 4'd14,
    F_RSVD    = 4'd15
  } fault_e;

  localparam int          OFS_W      = 16;
  localparam logic [15:0] RESET_OFS  = 16'h0001;
  localparam int          INSN_BYTES = 4;

endpackage

// File: rtl/trap_vector_rom.sv
module trap_vector_rom
  import tev_pkg::*;
(
  input  fault_e            code_i,
  output logic [OFS_W-1:0]  ofs_o
);

  always_comb begin
    case (code_i)
      F_MCHK:              ofs_o = 16'h0401;
      F_ARITH, F_OVF:      ofs_o = 16'h0501;
      F_INTR:              ofs_o = 16'h0101;
      F_NDTB:              ofs_o = 16'h0201;
      F_PDTB:              ofs_o = 16'h0281;
      F_ALIGN:             ofs_o = 16'h0301;
      F_DTBF, F_DTBACV:    ofs_o = 16'h0381;
      F_ITBMISS, F_ITBF:   ofs_o = 16'h0181;
      F_ITBACV:            ofs_o = 16'h0081;
      F_FEN:               ofs_o = 16'h0581;
      F_PALCALL:           ofs_o = 16'h2001;
      default:             ofs_o = 16'h0481;
    endcase
  end

endmodule

// File: rtl/trap_seq.sv
module trap_seq
  import tev_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [XLEN-1:0]  base_i,
  input  logic [XLEN-1:0]  pc_i,
  input  logic             trap_req_i,
  input  fault_e           fault_i,
  input  logic             ret_req_i,
  output fault_e           code_sel_o,
  input  logic [OFS_W-1:0] ofs_i,
  output logic [XLEN-1:0]  pc_o,
  output logic [XLEN-1:0]  npc_o,
  output logic [XLEN-1:0]  exc_addr_o,
  output logic             shadow_o,
  output logic             jump_o,
  output logic             recheck_o,
  output logic             state_err_o
);

  localparam logic [XLEN-1:0] STEP     = XLEN'(INSN_BYTES);
  localparam logic [XLEN-1:0] RST_OFFS = XLEN'(RESET_OFS);

  logic            in_handler;
  logic            take_trap;
  logic            skip_insn;
  logic            keep_exc;
  logic [XLEN-1:0] target;

  assign in_handler = pc_i[0];
  assign take_trap  = trap_req_i | (ret_req_i & ~in_handler);
  assign code_sel_o = trap_req_i ? fault_i : F_OPCODE;

  always_comb begin
    target    = base_i + XLEN'(ofs_i);
    skip_insn = (code_sel_o == F_ARITH) || (code_sel_o == F_PALCALL);
    keep_exc  = (code_sel_o == F_INTR) && in_handler;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_o    <= 1'b1;
      pc_o        <= base_i + RST_OFFS;
      npc_o       <= base_i + RST_OFFS + STEP;
      exc_addr_o  <= '0;
      jump_o      <= 1'b0;
      recheck_o   <= 1'b0;
      state_err_o <= 1'b0;
    end else begin
      jump_o      <= 1'b0;
      recheck_o   <= 1'b0;
      state_err_o <= 1'b0;
      if (take_trap) begin
        pc_o   <= target;
        npc_o  <= target + STEP;
        jump_o <= 1'b1;
        if (!keep_exc)
          exc_addr_o <= skip_insn ? pc_i + STEP : pc_i;
        if (!in_handler) begin
          shadow_o    <= 1'b1;
          state_err_o <= shadow_o;
        end
      end else if (ret_req_i) begin
        pc_o      <= exc_addr_o;
        npc_o     <= exc_addr_o + STEP;
        jump_o    <= 1'b1;
        recheck_o <= 1'b1;
        if (!exc_addr_o[0]) begin
          shadow_o    <= 1'b0;
          state_err_o <= ~shadow_o;
        end
      end
    end
  end

endmodule

// File: rtl/shadow_bank.sv
module shadow_bank #(
  parameter int XLEN  = 64,
  parameter int AW    = 5,
  parameter int LO    = 8,
  parameter int HI    = 14,
  parameter int EXTRA = 25
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            shadow_i,
  input  logic            we_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [XLEN-1:0] wdata_i,
  output logic [XLEN-1:0] rdata_o,
  output logic            hit_o
);

  localparam int            DEPTH   = HI - LO + 2;
  localparam int            IW      = $clog2(DEPTH);
  localparam logic [AW-1:0] LO_A    = AW'(LO);
  localparam logic [AW-1:0] HI_A    = AW'(HI);
  localparam logic [AW-1:0] EXTRA_A = AW'(EXTRA);
  localparam logic [IW-1:0] LAST    = IW'(DEPTH - 1);

  logic [XLEN-1:0] mem [DEPTH];
  logic            in_range;
  logic            is_extra;
  logic            hit_c;
  logic [AW-1:0]   off;
  logic [IW-1:0]   idx;

  always_comb begin
    in_range = (addr_i >= LO_A) && (addr_i <= HI_A);
    is_extra = (addr_i == EXTRA_A);
    hit_c    = shadow_i & (in_range | is_extra);
    off      = addr_i - LO_A;
    if (is_extra)      idx = LAST;
    else if (in_range) idx = off[IW-1:0];
    else               idx = '0;
  end

  always_ff @(posedge clk) begin
    if (we_i && hit_c)
      mem[idx] <= wdata_i;
    rdata_o <= mem[idx];
  end

  always_ff @(posedge clk) begin
    if (rst) hit_o <= 1'b0;
    else     hit_o <= hit_c;
  end

endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit
  import tev_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int AW   = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [XLEN-1:0] base_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic            trap_req_i,
  input  logic [3:0]      fault_i,
  input  logic            ret_req_i,
  input  logic            rf_we_i,
  input  logic [AW-1:0]   rf_addr_i,
  input  logic [XLEN-1:0] rf_wdata_i,
  output logic [XLEN-1:0] pc_o,
  output logic [XLEN-1:0] npc_o,
  output logic [XLEN-1:0] exc_addr_o,
  output logic            shadow_o,
  output logic            jump_o,
  output logic            recheck_o,
  output logic            state_err_o,
  output logic [XLEN-1:0] rf_rdata_o,
  output logic            rf_hit_o
);

  fault_e           code_sel;
  logic [OFS_W-1:0] ofs;

  trap_vector_rom u_rom (
    .code_i (code_sel),
    .ofs_o  (ofs)
  );

  trap_seq #(.XLEN(XLEN)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .base_i      (base_i),
    .pc_i        (pc_i),
    .trap_req_i  (trap_req_i),
    .fault_i     (fault_e'(fault_i)),
    .ret_req_i   (ret_req_i),
    .code_sel_o  (code_sel),
    .ofs_i       (ofs),
    .pc_o        (pc_o),
    .npc_o       (npc_o),
    .exc_addr_o  (exc_addr_o),
    .shadow_o    (shadow_o),
    .jump_o      (jump_o),
    .recheck_o   (recheck_o),
    .state_err_o (state_err_o)
  );

  shadow_bank #(.XLEN(XLEN), .AW(AW)) u_bank (
    .clk      (clk),
    .rst      (rst),
    .shadow_i (shadow_o),
    .we_i     (rf_we_i),
    .addr_i   (rf_addr_i),
    .wdata_i  (rf_wdata_i),
    .rdata_o  (rf_rdata_o),
    .hit_o    (rf_hit_o)
  );

endmodule

// File: rtl/trap_entry_chk.sv
module trap_entry_chk #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst,
  input logic            trap_req_i,
  input logic            ret_req_i,
  input logic [3:0]      fault_i,
  input logic [XLEN-1:0] pc_i,
  input logic [XLEN-1:0] pc_o,
  input logic [XLEN-1:0] npc_o,
  input logic [XLEN-1:0] exc_addr_o,
  input logic            shadow_o,
  input logic            jump_o,
  input logic            recheck_o,
  input logic            state_err_o
);

  // R2: every entry vector lands in handler mode
  p_vec_odd_r2: assert property (@(posedge clk) disable iff (rst)
    trap_req_i |=> (jump_o && pc_o[0]));

  // R3: the following PC is always one instruction on
  p_npc_step_r3: assert property (@(posedge clk) disable iff (rst)
    jump_o |-> (npc_o == pc_o + 64'd4));

  // R4: an interrupt inside the handler keeps the saved address
  p_intr_keep_r4: assert property (@(posedge clk) disable iff (rst)
    (trap_req_i && fault_i == 4'd2 && pc_i[0]) |=> $stable(exc_addr_o));

  // R6: entering from ordinary code selects the shadow bank
  p_enter_shadow_r6: assert property (@(posedge clk) disable iff (rst)
    (trap_req_i && !pc_i[0]) |=> shadow_o);

  // R9: redundant shadow entry is flagged
  p_redundant_r9: assert property (@(posedge clk) disable iff (rst)
    (trap_req_i && !pc_i[0] && shadow_o) |=> state_err_o);

  // R10: a trap in the same cycle suppresses the return side effects
  p_trap_wins_r10: assert property (@(posedge clk) disable iff (rst)
    (trap_req_i && ret_req_i) |=> !recheck_o);

  // R7: recheck only follows a legal return
  p_recheck_src_r7: assert property (@(posedge clk) disable iff (rst)
    recheck_o |-> ($past(ret_req_i) && $past(pc_i[0]) && jump_o));

endmodule

bind trap_entry_unit trap_entry_chk #(.XLEN(XLEN)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .trap_req_i  (trap_req_i),
  .ret_req_i   (ret_req_i),
  .fault_i     (fault_i),
  .pc_i        (pc_i),
  .pc_o        (pc_o),
  .npc_o       (npc_o),
  .exc_addr_o  (exc_addr_o),
  .shadow_o    (shadow_o),
  .jump_o      (jump_o),
  .recheck_o   (recheck_o),
  .state_err_o (state_err_o)
);

// File: tb/trap_entry_unit_test.sv
module trap_entry_unit_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic [63:0] base_i, pc_i, rf_wdata_i;
  logic        trap_req_i, ret_req_i, rf_we_i;
  logic [3:0]  fault_i;
  logic [4:0]  rf_addr_i;
  logic [63:0] pc_o, npc_o, exc_addr_o, rf_rdata_o;
  logic        shadow_o, jump_o, recheck_o, state_err_o, rf_hit_o;

  int checks = 0;
  int errors = 0;

  logic        m_sh;
  logic [63:0] m_exc;

  always #(CLK_PERIOD/2) clk = ~clk;

  trap_entry_unit uut (
    .clk(clk), .rst(rst), .base_i(base_i), .pc_i(pc_i),
    .trap_req_i(trap_req_i), .fault_i(fault_i), .ret_req_i(ret_req_i),
    .rf_we_i(rf_we_i), .rf_addr_i(rf_addr_i), .rf_wdata_i(rf_wdata_i),
    .pc_o(pc_o), .npc_o(npc_o), .exc_addr_o(exc_addr_o),
    .shadow_o(shadow_o), .jump_o(jump_o), .recheck_o(recheck_o),
    .state_err_o(state_err_o), .rf_rdata_o(rf_rdata_o), .rf_hit_o(rf_hit_o)
  );

  function automatic logic [63:0] vec(input logic [3:0] c);
    case (c)
      4'd0: return 64'h0401;
      4'd1, 4'd14: return 64'h0501;
      4'd2: return 64'h0101;
      4'd3: return 64'h0201;
      4'd4: return 64'h0281;
      4'd5: return 64'h0301;
      4'd6, 4'd7: return 64'h0381;
      4'd8, 4'd9: return 64'h0181;
      4'd10: return 64'h0081;
      4'd12: return 64'h0581;
      4'd13: return 64'h2001;
      default: return 64'h0481;
    endcase
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Drive one request at a negedge, check outputs at the next negedge.
  task automatic op(input string tag, input bit tr, input logic [3:0] code,
                    input bit rt, input logic [63:0] pc, input logic [63:0] base);
    logic [63:0] e_pc;
    logic        e_rc, e_err;
    logic [3:0]  f;
    e_rc = 1'b0; e_err = 1'b0;
    if (tr || (rt && !pc[0])) begin
      f = tr ? code : 4'd11;
      e_pc = base + vec(f);
      if (!(f == 4'd2 && pc[0]))
        m_exc = pc + (((f == 4'd1) || (f == 4'd13)) ? 64'd4 : 64'd0);
      if (!pc[0]) begin e_err = m_sh; m_sh = 1'b1; end
    end else begin
      e_pc = m_exc;
      e_rc = 1'b1;
      if (!m_exc[0]) begin e_err = ~m_sh; m_sh = 1'b0; end
    end
    trap_req_i = tr; ret_req_i = rt; fault_i = code; pc_i = pc; base_i = base;
    @(posedge clk);
    @(negedge clk);
    trap_req_i = 1'b0; ret_req_i = 1'b0;
    chk(tag, "pc_o", pc_o, e_pc);
    chk("R3", "npc_o", npc_o, e_pc + 64'd4);
    chk("R3", "jump_o", {63'd0, jump_o}, 64'd1);
    chk("R4", "exc_addr_o", exc_addr_o, m_exc);
    chk("R6", "shadow_o", {63'd0, shadow_o}, {63'd0, m_sh});
    chk("R7", "recheck_o", {63'd0, recheck_o}, {63'd0, e_rc});
    chk("R9", "state_err_o", {63'd0, state_err_o}, {63'd0, e_err});
  endtask

  task automatic rf(input bit we, input logic [4:0] a, input logic [63:0] d,
                    input bit e_hit, input bit chk_data, input logic [63:0] e_d);
    rf_we_i = we; rf_addr_i = a; rf_wdata_i = d;
    @(posedge clk);
    @(negedge clk);
    rf_we_i = 1'b0;
    chk("R11", "rf_hit_o", {63'd0, rf_hit_o}, {63'd0, e_hit});
    if (chk_data) chk("R11", "rf_rdata_o", rf_rdata_o, e_d);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; trap_req_i = 1'b0; ret_req_i = 1'b0; fault_i = '0;
    pc_i = '0; base_i = 64'h0000_0000_8000_0000;
    rf_we_i = 1'b0; rf_addr_i = '0; rf_wdata_i = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "pc_o", pc_o, 64'h8000_0001);
    chk("R1", "npc_o", npc_o, 64'h8000_0005);
    chk("R1", "exc_addr_o", exc_addr_o, 64'd0);
    chk("R1", "shadow_o", {63'd0, shadow_o}, 64'd1);
    chk("R1", "pulses", {61'd0, jump_o, recheck_o, state_err_o}, 64'd0);
    rst = 1'b0;
    m_sh = 1'b1; m_exc = '0;

    // R11: shadow array under shadow mode
    rf(1'b1, 5'd8,  64'hAAAA_0008, 1'b1, 1'b0, '0);
    rf(1'b1, 5'd25, 64'hBBBB_0025, 1'b1, 1'b0, '0);
    rf(1'b1, 5'd14, 64'hCCCC_0014, 1'b1, 1'b0, '0);
    rf(1'b0, 5'd15, 64'd0, 1'b0, 1'b0, '0);
    rf(1'b0, 5'd7,  64'd0, 1'b0, 1'b0, '0);
    rf(1'b0, 5'd8,  64'd0, 1'b1, 1'b1, 64'hAAAA_0008);
    rf(1'b0, 5'd25, 64'd0, 1'b1, 1'b1, 64'hBBBB_0025);

    // R7: legal return to even saved address leaves shadow
    op("R7", 1'b0, 4'd0, 1'b1, 64'h8000_0001, base_i);
    // R9: second legal return while shadow already off
    op("R9", 1'b0, 4'd0, 1'b1, 64'h8000_0101, base_i);
    // R11: writes outside shadow mode do not reach the array
    rf(1'b1, 5'd8, 64'hDEAD_0008, 1'b0, 1'b0, '0);

    // R2/R4/R5/R6/R12: sweep every code from ordinary and handler PCs
    for (int c = 0; c < 16; c++) begin
      for (int hm = 0; hm < 2; hm++) begin
        logic [63:0] b, p;
        b = 64'hFFFF_0000_0000_0000 + (64'(c) << 20);
        p = 64'h0000_0001_2345_6700 + (64'(c) << 4) + 64'(hm);
        op((c == 15) ? "R12" : ((c == 1 || c == 13) ? "R5" : "R2"),
           1'b1, 4'(c), 1'b0, p, b);
      end
    end

    // R11: old shadow value survives the excursion
    rf(1'b0, 5'd8, 64'd0, 1'b1, 1'b1, 64'hAAAA_0008);

    // R7: saved odd address -> return keeps shadow
    op("R4", 1'b1, 4'd5, 1'b0, 64'h0000_0000_0000_4441, 64'h10000);
    op("R7", 1'b0, 4'd0, 1'b1, 64'h0000_0000_0001_0301, 64'h10000);
    // R4: interrupt from handler mode keeps saved address
    op("R4", 1'b1, 4'd2, 1'b0, 64'h0000_0000_0000_9991, 64'h20000);
    // R8: illegal return from ordinary code
    op("R8", 1'b0, 4'd0, 1'b1, 64'h0000_0000_0000_5550, 64'h30000);
    // R10: trap and return together
    op("R10", 1'b1, 4'd13, 1'b1, 64'h0000_0000_0000_6661, 64'h40000);
    op("R7", 1'b0, 4'd0, 1'b1, 64'h0000_0000_0000_0001, 64'h40000);
    op("R10", 1'b1, 4'd3, 1'b1, 64'h0000_0000_0000_7770, 64'h50000);
    op("R7", 1'b0, 4'd0, 1'b1, 64'h0000_0000_0000_0001, 64'h50000);

    // R3: jump_o is a single-cycle pulse
    @(negedge clk);
    chk("R3", "jump_o idle", {63'd0, jump_o}, 64'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule